// File: doc/BRIEF.md
# Bit Test and Modify Unit

This unit reads one bit of a 16-bit or 32-bit word and returns that bit's original value as a carry flag. Depending on the command, it then leaves the word alone, sets the bit, clears it or inverts it. The word comes from one of two places. It is either a register value given on an input port, or a word in memory that the unit reads and writes through a request/acknowledge port. The bit position comes from a register offset or from an 8-bit immediate.

When the target is in memory and the offset comes from a register, the offset can point outside the base word. The low bits pick the bit within a word. The remaining bits are a signed count of whole words, measured from the base address, and each word is 4 bytes wide in 32-bit mode and 2 bytes wide in 16-bit mode. An immediate offset always wraps inside the base word.

A caller pulses `start` with the command fields valid and waits for `done`. A register target finishes in one cycle and returns the updated word on `regResult`. A memory target finishes after its last memory handshake.

Top module: `bit_modify_unit`

## Requirements
- R1: `carryOut`, valid while `done` is high, equals the value the selected bit had before any change, for both register and memory targets.
- R2: `opSel` encodes the operation: 2'b00 test only (nothing written back), 2'b01 set the bit to 1, 2'b10 clear the bit to 0, 2'b11 invert the bit; all other bits of the word are unchanged.
- R3: For a register target with a register offset, the bit index is `regOffset` modulo 32 when `wideMode`=1 and modulo 16 when `wideMode`=0.
- R4: For a register target, `done` is high in the cycle after the `start` edge, `regResult` holds the updated word (upper half passed through in 16-bit mode), and `regWrEn` is high with `done` for set/clear/invert and low for test.
- R5: For a memory target with a register offset (`useImm`=0), the access address is `baseAddr` + 4*floor(signed `regOffset` / 32) in 32-bit mode, or `baseAddr` + 2*floor(signed `regOffset[15:0]` / 16) in 16-bit mode, and the bit index is the offset modulo 32 or 16.
- R6: With `useImm`=1, the bit index is `immOffset` modulo 32 (32-bit mode) or modulo 16 (16-bit mode), and a memory access uses `baseAddr` unchanged.
- R7: A memory set/clear/invert makes exactly one read (`memWe`=0) and then one write (`memWe`=1) to the same address; the write request starts only after the read has been acknowledged; a memory test makes one read and no write. `memReq` and `memAddr` are held until `memAck`.
- R8: For a memory target, `done` pulses for one cycle, in the cycle after the final acknowledge (the read for test, the write otherwise).
- R9: A `start` pulse while a memory operation is in progress is ignored: it produces no `regWrEn`, no extra `done` and no change to the running access.
- R10: After reset, `done`, `memReq`, `memWe` and `regWrEn` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, accepted when idle |
| opSel | input | 2 | Operation code (R2) |
| wideMode | input | 1 | 1 = 32-bit word, 0 = 16-bit word |
| memTarget | input | 1 | 1 = memory word, 0 = register value |
| useImm | input | 1 | 1 = offset from `immOffset`, 0 = from `regOffset` |
| regValue | input | 32 | Register target word |
| regOffset | input | 32 | Register-supplied bit offset |
| immOffset | input | 8 | Immediate bit offset |
| baseAddr | input | 32 | Base byte address of the memory word |
| done | output | 1 | One-cycle completion pulse |
| carryOut | output | 1 | Original value of the selected bit |
| regResult | output | 32 | Updated register word |
| regWrEn | output | 1 | Write enable for `regResult` |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 = write access, 0 = read access |
| memWide | output | 1 | Access size, 1 = 32-bit, 0 = 16-bit |
| memAddr | output | 32 | Access byte address |
| memWdata | output | 32 | Write data (low half used in 16-bit mode) |
| memAck | input | 1 | Access acknowledge; read data valid with it |
| memRdata | input | 32 | Read data |

## Verification
A register command registers its results on the `start` edge, so `done`, `carryOut`, `regResult` and `regWrEn` are checked on the falling edge one cycle later. The bench memory answers each request on the falling edge after it first sees it, and drops the acknowledge on the next falling edge. With that memory, a memory test raises `done` two cycles after the `start` edge and a memory modify raises it four cycles after. Every check counts cycles from the `start` edge and compares the count exactly against those figures. Addresses, access counts and the memory contents are read from the bench memory model after `done`, and all outputs are sampled on falling edges.

// File: rtl/bitmod_pkg.sv
package bitmod_pkg;

  typedef enum logic [1:0] {
    OP_TEST = 2'b00,
    OP_SET  = 2'b01,
    OP_CLR  = 2'b10,
    OP_FLIP = 2'b11
  } bitOp_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic latchCmd;   // capture command fields, index and address
    logic finishReg;  // register target: produce result this edge
    logic latchRead;  // memory read data is valid this edge
  } ctrlStrobe_t;

endpackage

// File: rtl/bitmod_datapath.sv
module bitmod_datapath
  import bitmod_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int HALF_W = 16,
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  bitOp_e            opIn,
  input  logic              wideIn,
  input  logic              useImm,
  input  logic [WORD_W-1:0] regValue,
  input  logic [WORD_W-1:0] regOffset,
  input  logic [IMM_W-1:0]  immOffset,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [WORD_W-1:0] memRdata,
  output logic              carryOut,
  output logic [WORD_W-1:0] regResult,
  output logic              regWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic              memWide
);

  localparam int IDX_W    = $clog2(WORD_W);
  localparam int HIDX_W   = $clog2(HALF_W);
  localparam int WIDE_SH  = $clog2(WORD_W / 8);
  localparam int HALF_SH  = $clog2(HALF_W / 8);

  logic [WORD_W-1:0]        offSel;
  logic [IDX_W-1:0]         idxNow;
  logic signed [WORD_W-1:0] halfExt;
  logic signed [WORD_W-1:0] wordCnt;
  logic signed [WORD_W-1:0] byteDelta;
  logic [ADDR_W-1:0]        addrNow;

  bitOp_e            opQ;
  logic              wideQ;
  logic [IDX_W-1:0]  idxQ;
  logic [ADDR_W-1:0] addrQ;
  logic [WORD_W-1:0] wordQ;
  logic              carryQ;
  logic [WORD_W-1:0] regResultQ;
  logic              regWrEnQ;

  function automatic logic [WORD_W-1:0] modifyWord(
    input logic [WORD_W-1:0] w,
    input bitOp_e            op,
    input logic [IDX_W-1:0]  idx
  );
    logic [WORD_W-1:0] m;
    m = '0;
    m[idx] = 1'b1;
    case (op)
      OP_SET:  return w | m;
      OP_CLR:  return w & ~m;
      OP_FLIP: return w ^ m;
      default: return w;
    endcase
  endfunction

  // Offset source and bit index: low bits of the chosen offset
  always_comb begin
    offSel = useImm ? {{(WORD_W-IMM_W){1'b0}}, immOffset} : regOffset;
    if (wideIn) idxNow = offSel[IDX_W-1:0];
    else        idxNow = {{(IDX_W-HIDX_W){1'b0}}, offSel[HIDX_W-1:0]};
  end

  // Signed word count from the upper offset bits, scaled by word size
  always_comb begin
    halfExt = $signed({{(WORD_W-HALF_W){regOffset[HALF_W-1]}}, regOffset[HALF_W-1:0]});
    if (wideIn) begin
      wordCnt   = $signed(regOffset) >>> IDX_W;
      byteDelta = wordCnt <<< WIDE_SH;
    end else begin
      wordCnt   = halfExt >>> HIDX_W;
      byteDelta = wordCnt <<< HALF_SH;
    end
    if (useImm) addrNow = baseAddr;
    else        addrNow = baseAddr + ADDR_W'(byteDelta);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ        <= OP_TEST;
      wideQ      <= 1'b0;
      idxQ       <= '0;
      addrQ      <= '0;
      wordQ      <= '0;
      carryQ     <= 1'b0;
      regResultQ <= '0;
      regWrEnQ   <= 1'b0;
    end else begin
      regWrEnQ <= 1'b0;
      if (strb.latchCmd) begin
        opQ   <= opIn;
        wideQ <= wideIn;
        idxQ  <= idxNow;
        addrQ <= addrNow;
      end
      if (strb.finishReg) begin
        carryQ     <= regValue[idxNow];
        regResultQ <= modifyWord(regValue, opIn, idxNow);
        regWrEnQ   <= (opIn != OP_TEST);
      end
      if (strb.latchRead) begin
        carryQ <= memRdata[idxQ];
        wordQ  <= modifyWord(memRdata, opQ, idxQ);
      end
    end
  end

  assign carryOut  = carryQ;
  assign regResult = regResultQ;
  assign regWrEn   = regWrEnQ;
  assign memAddr   = addrQ;
  assign memWdata  = wordQ;
  assign memWide   = wideQ;

  // R2: a set leaves the selected bit at 1 in the word to be written
  a_r2_set_forces_one: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.latchRead) && opQ == OP_SET) |-> wordQ[idxQ]);

  // R2: a clear leaves the selected bit at 0 in the word to be written
  a_r2_clr_forces_zero: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.latchRead) && opQ == OP_CLR) |-> !wordQ[idxQ]);

  // R1: carry follows the read word's bit at the captured index
  a_r1_carry_from_read: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchRead |=> (carryOut == $past(memRdata[idxQ])));

endmodule

// File: rtl/bitmod_control.sv
module bitmod_control
  import bitmod_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        memTarget,
  input  bitOp_e      opIn,
  input  logic        memAck,
  output ctrlStrobe_t strb,
  output logic        memReq,
  output logic        memWe,
  output logic        done
);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } seqState_e;

  seqState_e state;
  seqState_e stateNext;
  logic      testQ;
  logic      doneQ;
  logic      doneNext;

  always_comb begin
    strb.latchCmd  = (state == ST_IDLE) && start;
    strb.finishReg = strb.latchCmd && !memTarget;
    strb.latchRead = (state == ST_READ) && memAck;
  end

  always_comb begin
    stateNext = state;
    doneNext  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          if (memTarget) stateNext = ST_READ;
          else           doneNext  = 1'b1;
        end
      end
      ST_READ: begin
        if (memAck) begin
          if (testQ) begin
            stateNext = ST_IDLE;
            doneNext  = 1'b1;
          end else begin
            stateNext = ST_WRITE;
          end
        end
      end
      ST_WRITE: begin
        if (memAck) begin
          stateNext = ST_IDLE;
          doneNext  = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      testQ <= 1'b0;
      doneQ <= 1'b0;
    end else begin
      state <= stateNext;
      doneQ <= doneNext;
      if (strb.latchCmd) testQ <= (opIn == OP_TEST);
    end
  end

  assign memReq = (state != ST_IDLE);
  assign memWe  = (state == ST_WRITE);
  assign done   = doneQ;

  // R7: a write request only begins right after an acknowledged read
  a_r7_write_after_read: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWe) |-> ($past(memAck) && !$past(memWe)));

  // R7: a request is held until it is acknowledged
  a_r7_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memWe)));

  // R2: a test command never reaches the write phase
  a_r2_test_no_write: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> !testQ);

  // R4: a register command completes on the next cycle
  a_r4_reg_done_next: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && start && !memTarget) |=> done);

  // R9: a start during a memory access does not restart the sequence
  a_r9_busy_keeps_req: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck && start) |=> memReq);

endmodule

// File: rtl/bit_modify_unit.sv
module bit_modify_unit
  import bitmod_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int HALF_W = 16,
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        opSel,
  input  logic              wideMode,
  input  logic              memTarget,
  input  logic              useImm,
  input  logic [WORD_W-1:0] regValue,
  input  logic [WORD_W-1:0] regOffset,
  input  logic [IMM_W-1:0]  immOffset,
  input  logic [ADDR_W-1:0] baseAddr,
  output logic              done,
  output logic              carryOut,
  output logic [WORD_W-1:0] regResult,
  output logic              regWrEn,
  output logic              memReq,
  output logic              memWe,
  output logic              memWide,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  input  logic              memAck,
  input  logic [WORD_W-1:0] memRdata
);

  ctrlStrobe_t strb;
  bitOp_e      opIn;

  assign opIn = bitOp_e'(opSel);

  bitmod_control u_control (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .memTarget (memTarget),
    .opIn      (opIn),
    .memAck    (memAck),
    .strb      (strb),
    .memReq    (memReq),
    .memWe     (memWe),
    .done      (done)
  );

  bitmod_datapath #(
    .WORD_W (WORD_W),
    .HALF_W (HALF_W),
    .ADDR_W (ADDR_W),
    .IMM_W  (IMM_W)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .opIn      (opIn),
    .wideIn    (wideMode),
    .useImm    (useImm),
    .regValue  (regValue),
    .regOffset (regOffset),
    .immOffset (immOffset),
    .baseAddr  (baseAddr),
    .memRdata  (memRdata),
    .carryOut  (carryOut),
    .regResult (regResult),
    .regWrEn   (regWrEn),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .memWide   (memWide)
  );

  // R4: the register write enable only appears together with done
  a_r4_wren_with_done: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> done);

  // R7: address and direction stay fixed while a request waits
  a_r7_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> $stable(memAddr));

  // R10: nothing is requested or signalled right after reset
  a_r10_quiet_after_reset: assert property (@(posedge clk)
    $rose(rstN) |-> (!done && !memReq && !regWrEn));

endmodule

// File: tb/bit_modify_unit_bench.sv
module bit_modify_unit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  opSel = 2'b00;
  logic        wideMode = 1'b1;
  logic        memTarget = 1'b0;
  logic        useImm = 1'b0;
  logic [31:0] regValue = '0;
  logic [31:0] regOffset = '0;
  logic [7:0]  immOffset = '0;
  logic [31:0] baseAddr = '0;
  logic        done, carryOut, regWrEn, memReq, memWe, memWide;
  logic [31:0] regResult, memAddr, memWdata;
  logic        memAck = 1'b0;
  logic [31:0] memRdata = '0;

  int checks = 0;
  int failures = 0;

  logic [7:0]  memB [0:255];
  int          rdCount = 0;
  int          wrCount = 0;
  logic [31:0] lastRdAddr = '0;
  logic [31:0] lastWrAddr = '0;

  always #4 clk = ~clk;

  bit_modify_unit u_bit_modify_unit (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .wideMode(wideMode),
    .memTarget(memTarget), .useImm(useImm), .regValue(regValue),
    .regOffset(regOffset), .immOffset(immOffset), .baseAddr(baseAddr),
    .done(done), .carryOut(carryOut), .regResult(regResult), .regWrEn(regWrEn),
    .memReq(memReq), .memWe(memWe), .memWide(memWide), .memAddr(memAddr),
    .memWdata(memWdata), .memAck(memAck), .memRdata(memRdata)
  );

  function automatic logic [31:0] readMem(input logic [31:0] a, input logic wide);
    logic [7:0] p;
    logic [31:0] w;
    p = a[7:0];
    w = {16'h0, memB[8'(p + 8'd1)], memB[p]};
    if (wide) w[31:16] = {memB[8'(p + 8'd3)], memB[8'(p + 8'd2)]};
    return w;
  endfunction

  task automatic writeMem(input logic [31:0] a, input logic wide, input logic [31:0] w);
    logic [7:0] p;
    p = a[7:0];
    memB[p]              = w[7:0];
    memB[8'(p + 8'd1)]   = w[15:8];
    if (wide) begin
      memB[8'(p + 8'd2)] = w[23:16];
      memB[8'(p + 8'd3)] = w[31:24];
    end
  endtask

  // Memory model: answers a request on the next falling edge, then drops ack
  always @(negedge clk) begin
    if (memAck) begin
      memAck = 1'b0;
    end else if (memReq) begin
      memAck = 1'b1;
      if (memWe) begin
        writeMem(memAddr, memWide, memWdata);
        wrCount++;
        lastWrAddr = memAddr;
      end else begin
        memRdata = readMem(memAddr, memWide);
        rdCount++;
        lastRdAddr = memAddr;
      end
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  function automatic int unsigned expIdx(input logic wide, input logic imm,
                                         input logic [31:0] off, input logic [7:0] iv);
    int unsigned width;
    width = wide ? 32 : 16;
    if (imm) return int'(iv) % width;
    if (wide) return off % width;
    return int'(off[15:0]) % width;
  endfunction

  function automatic logic [31:0] expAddr(input logic wide, input logic imm,
                                          input logic [31:0] off, input logic [31:0] base);
    int s, cnt;
    if (imm) return base;
    if (wide) begin
      s   = int'(off);
      cnt = (s - (s & 31)) / 32;
      return base + 32'(4 * cnt);
    end
    s   = int'(shortint'(off[15:0]));
    cnt = (s - (s & 15)) / 16;
    return base + 32'(2 * cnt);
  endfunction

  function automatic logic [31:0] expWord(input logic [31:0] w, input logic [1:0] op,
                                          input int unsigned idx);
    logic [31:0] r;
    r = w;
    if (op == 2'b01) r[idx] = 1'b1;
    else if (op == 2'b10) r[idx] = 1'b0;
    else if (op == 2'b11) r[idx] = ~w[idx];
    return r;
  endfunction

  task automatic pulseStart();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic testReset();
    check("R10", "done after reset",    {31'b0, done},    32'h0);
    check("R10", "memReq after reset",  {31'b0, memReq},  32'h0);
    check("R10", "memWe after reset",   {31'b0, memWe},   32'h0);
    check("R10", "regWrEn after reset", {31'b0, regWrEn}, 32'h0);
  endtask

  task automatic regOp(input string req, input logic [1:0] op, input logic wide,
                       input logic imm, input logic [31:0] val,
                       input logic [31:0] off, input logic [7:0] iv);
    int unsigned idx;
    idx = expIdx(wide, imm, off, iv);
    @(negedge clk);
    opSel = op; wideMode = wide; memTarget = 1'b0; useImm = imm;
    regValue = val; regOffset = off; immOffset = iv;
    pulseStart();
    check(req, "reg done one cycle after start", {31'b0, done}, 32'h1);
    check("R1", "reg carry", {31'b0, carryOut}, {31'b0, val[idx]});
    check(req, "reg result", regResult, expWord(val, op, idx));
    check("R4", "reg write enable", {31'b0, regWrEn}, {31'b0, op != 2'b00});
    @(negedge clk);
    check("R4", "done is one pulse", {31'b0, done}, 32'h0);
  endtask

  task automatic memOp(input string req, input logic [1:0] op, input logic wide,
                       input logic imm, input logic [31:0] base,
                       input logic [31:0] off, input logic [7:0] iv,
                       input logic [31:0] init);
    int unsigned idx;
    logic [31:0] a, mask;
    int cyc, rd0, wr0;
    idx  = expIdx(wide, imm, off, iv);
    a    = expAddr(wide, imm, off, base);
    mask = wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    @(negedge clk);
    writeMem(a, wide, init);
    rd0 = rdCount; wr0 = wrCount;
    opSel = op; wideMode = wide; memTarget = 1'b1; useImm = imm;
    baseAddr = base; regOffset = off; immOffset = iv;
    regValue = 32'hDEAD_BEEF;
    pulseStart();
    cyc = 1;
    while (!done && cyc < 20) begin
      @(negedge clk);
      cyc++;
    end
    check("R8", "mem cycles start to done", 32'(cyc), (op == 2'b00) ? 32'd2 : 32'd4);
    check("R1", "mem carry", {31'b0, carryOut}, {31'b0, init[idx]});
    check(req, "read address", lastRdAddr, a);
    check("R7", "read count", 32'(rdCount - rd0), 32'd1);
    check("R7", "write count", 32'(wrCount - wr0), (op == 2'b00) ? 32'd0 : 32'd1);
    if (op != 2'b00) check("R7", "write address equals read address", lastWrAddr, a);
    check("R2", "memory word after op", readMem(a, wide) & mask,
          expWord(init, op, idx) & mask);
    check("R4", "no reg write on memory op", {31'b0, regWrEn}, 32'h0);
    @(negedge clk);
    check("R8", "done is one pulse", {31'b0, done}, 32'h0);
  endtask

  task automatic overlapStart();
    logic [31:0] a;
    int cyc, doneCnt, wrenCnt, rd0;
    a = 32'h0000_0090;
    @(negedge clk);
    writeMem(a, 1'b1, 32'h0000_0000);
    rd0 = rdCount;
    opSel = 2'b01; wideMode = 1'b1; memTarget = 1'b1; useImm = 1'b1;
    baseAddr = a; immOffset = 8'd3;
    pulseStart();
    // R9: a second start during the read, aimed at a register target
    opSel = 2'b11; memTarget = 1'b0; useImm = 1'b0; regValue = 32'h0; regOffset = 32'd1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 2; doneCnt = 0; wrenCnt = 0;
    while (cyc < 10) begin
      if (done) doneCnt++;
      if (regWrEn) wrenCnt++;
      @(negedge clk);
      cyc++;
    end
    check("R9", "single done despite busy start", 32'(doneCnt), 32'd1);
    check("R9", "no reg write from busy start", 32'(wrenCnt), 32'd0);
    check("R9", "one read only", 32'(rdCount - rd0), 32'd1);
    check("R9", "memory op unaffected", readMem(a, 1'b1), 32'h0000_0008);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) memB[i] = 8'(i * 37 + 5);
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();

    // R3: offsets wrap inside the register word
    regOp("R3", 2'b01, 1'b1, 1'b0, 32'h0000_0000, 32'hFFFF_FFFF, 8'd0);
    regOp("R3", 2'b00, 1'b0, 1'b0, 32'h0000_0008, 32'h0000_0013, 8'd0);
    regOp("R2", 2'b10, 1'b1, 1'b0, 32'h1234_5678, 32'd4, 8'd0);
    // R6: immediate offsets on register targets
    regOp("R6", 2'b10, 1'b1, 1'b1, 32'hFFFF_FFFF, 32'd0, 8'd40);
    regOp("R6", 2'b11, 1'b0, 1'b1, 32'hABCD_1234, 32'd0, 8'h1F);
    regOp("R2", 2'b11, 1'b1, 1'b0, 32'h8000_0001, 32'd0, 8'd0);

    // R5: register offsets reaching neighbour words
    memOp("R5", 2'b01, 1'b1, 1'b0, 32'h80, 32'd70,          8'd0, 32'h0000_0000);
    memOp("R5", 2'b11, 1'b1, 1'b0, 32'h80, 32'hFFFF_FFDF,   8'd0, 32'hFFFF_0000);
    memOp("R5", 2'b10, 1'b0, 1'b0, 32'h80, 32'h0000_FFEF,   8'd0, 32'h0000_FFFF);
    memOp("R5", 2'b00, 1'b0, 1'b0, 32'h80, 32'h0000_0025,   8'd0, 32'h0000_0020);
    // R6: immediate offsets keep the base address
    memOp("R6", 2'b11, 1'b1, 1'b1, 32'h40, 32'h0000_0100,   8'h45, 32'h1234_5678);
    memOp("R6", 2'b10, 1'b0, 1'b1, 32'h20, 32'hFFFF_FFFF,   8'h1A, 32'h0000_FFFF);
    memOp("R7", 2'b00, 1'b1, 1'b1, 32'h60, 32'd0,           8'd7,  32'h0000_0080);

    overlapStart();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired before the end of the run");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule